// File: doc/BRIEF.md
# GPIO Bank Pin Register File

This block holds the pin-control state for one bank of general-purpose I/O pads. The bank has 32 pins arranged as four ports of eight. Every port has three writable control registers: a configuration register that puts each pin under GPIO control, a drive-enable register, and an output-level register. It also has one read-only register that returns the synchronised pad level. A pin drives its pad only when its configuration bit and its drive-enable bit are both set.

Software reaches each control register in two ways. A plain write replaces all eight bits of a port. A masked alias write changes only the pins selected in the second data byte, so one pin can change without a read-modify-write sequence. The bus is a simple synchronous register interface with an address, a write strobe, write data and registered read data. Interrupt detection and debounce are handled by separate blocks, and their offsets read as zero here.

Top module: `gpio_bank_regs`

## Requirements
- R1: Reset, whenever it is asserted, clears every configuration, drive-enable and output-level bit. While those are clear, pad_oe and pad_out are all zero, and every read returns zero except reads of the input-sample group.
- R2: The byte address is decoded as follows. Bits [6:4] select the register group: 0 is configuration, 1 is drive-enable, 2 is output-level and 3 is input-sample. Bits [3:2] select the port. Bits [1:0] are ignored. Bit 7 selects the masked alias. Pin `b` of port `p` is pad `p*8+b`.
- R3: A plain write (bit 7 = 0) to a control group loads bits [7:0] of the write data into all eight pins of the addressed port. Data bits [31:8] have no effect.
- R4: A masked write (bit 7 = 1) to a control group sets pin n to data bit n only when data bit 8+n is 1. All other pins keep their value, so a mask byte of zero changes nothing.
- R5: pad_oe for a pin is 1 exactly when both its configuration bit and its drive-enable bit are 1. pad_out carries the output-level bit for a driving pin and is 0 for a pin that is not driving.
- R6: The input-sample group returns the pad level after a two-flop synchronizer. A read issued in the cycle the pad changes, or in the cycle after, returns the old level. A read issued two cycles after the change returns the new level. Writes to this group, plain or alias, are ignored.
- R7: bus_rdata is registered. It shows the register selected by the address of the previous cycle, in bits [7:0], with bits [31:8] zero. A read issued in the cycle after a write returns the written value. An alias address reads the same value as its plain address.
- R8: Groups 4 to 7, plain or alias, read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data; byte 1 is the pin-select mask for alias writes |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output level per pad (0 when the pad is not driving) |
| pad_oe | output | 32 | Output enable per pad |

## Verification
The assertions assume two things about the inputs. The address and write strobe are stable across each rising edge. pad_in may change at any time, so no property depends on the value of the input-sample group. The bench meets these assumptions by changing all bus inputs and pad levels only on the falling clock edge.

Each read is issued for one cycle, and its expected value goes into a scoreboard queue that a monitor compares one cycle later. Pad changes are timed against reads issued in the same cycle, one cycle later and two cycles later, so the synchronizer delay is pinned down exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register group codes carried in the address group field
    localparam logic [2:0] GRP_CFG = 3'd0;
    localparam logic [2:0] GRP_DRV = 3'd1;
    localparam logic [2:0] GRP_LVL = 3'd2;
    localparam logic [2:0] GRP_SMP = 3'd3;

    localparam int GRP_W       = 3;
    localparam int WORD_LSB    = 2;
    localparam int DEF_PINS    = 8;
    localparam int DEF_PORTS   = 4;

    // Merge of a masked update into a stored pin vector
    function automatic logic [DEF_PINS-1:0] merge_pins(
        input logic [DEF_PINS-1:0] old_v,
        input logic [DEF_PINS-1:0] new_v,
        input logic [DEF_PINS-1:0] sel
    );
        return (old_v & ~sel) | (new_v & sel);
    endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int NPORT  = DEF_PORTS,
    parameter int PINS   = DEF_PINS,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       we,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NPORT-1:0]           wr_cfg,
    output logic [NPORT-1:0]           wr_drv,
    output logic [NPORT-1:0]           wr_lvl,
    output logic [PINS-1:0]            wmask,
    output logic [PINS-1:0]            wval,
    output logic [GRP_W-1:0]           rd_grp,
    output logic [$clog2(NPORT)-1:0]   rd_port
);

    localparam int PSEL_W    = $clog2(NPORT);
    localparam int GRP_LSB   = WORD_LSB + PSEL_W;
    localparam int ALIAS_BIT = GRP_LSB + GRP_W;

    logic                  is_alias;
    logic [GRP_W-1:0]      grp;
    logic [PSEL_W-1:0]     port;
    logic                  unused_bits;

    assign unused_bits = ^{addr[WORD_LSB-1:0], wdata[DATA_W-1:2*PINS]};

    always_comb begin
        is_alias = addr[ALIAS_BIT];
        grp      = addr[GRP_LSB +: GRP_W];
        port     = addr[WORD_LSB +: PSEL_W];
        wval     = wdata[PINS-1:0];
        wmask    = is_alias ? wdata[PINS +: PINS] : {PINS{1'b1}};
        wr_cfg   = '0;
        wr_drv   = '0;
        wr_lvl   = '0;
        if (we) begin
            case (grp)
                GRP_CFG: wr_cfg[port] = 1'b1;
                GRP_DRV: wr_drv[port] = 1'b1;
                GRP_LVL: wr_lvl[port] = 1'b1;
                default: ;
            endcase
        end
        rd_grp  = grp;
        rd_port = port;
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_bank_pkg::*;
#(
    parameter int PINS = DEF_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_cfg,
    input  logic            wr_drv,
    input  logic            wr_lvl,
    input  logic [PINS-1:0] wmask,
    input  logic [PINS-1:0] wval,
    output logic [PINS-1:0] cfg,
    output logic [PINS-1:0] drv,
    output logic [PINS-1:0] lvl,
    output logic [PINS-1:0] port_oe,
    output logic [PINS-1:0] port_out
);

    typedef struct packed {
        logic [PINS-1:0] cfg;
        logic [PINS-1:0] drv;
        logic [PINS-1:0] lvl;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cfg) st_d.cfg = (st_q.cfg & ~wmask) | (wval & wmask);
        if (wr_drv) st_d.drv = (st_q.drv & ~wmask) | (wval & wmask);
        if (wr_lvl) st_d.lvl = (st_q.lvl & ~wmask) | (wval & wmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg      = st_q.cfg;
    assign drv      = st_q.drv;
    assign lvl      = st_q.lvl;
    assign port_oe  = st_q.cfg & st_q.drv;
    assign port_out = st_q.cfg & st_q.drv & st_q.lvl;

endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPORT       = DEF_PORTS,
    parameter int PINS        = DEF_PINS,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NPORT*PINS-1:0]  pad_in,
    output logic [NPORT*PINS-1:0]  pad_out,
    output logic [NPORT*PINS-1:0]  pad_oe
);

    localparam int NPIN   = NPORT * PINS;
    localparam int PSEL_W = $clog2(NPORT);

    logic [NPORT-1:0]        wr_cfg, wr_drv, wr_lvl;
    logic [PINS-1:0]         wmask, wval;
    logic [GRP_W-1:0]        rd_grp;
    logic [PSEL_W-1:0]       rd_port;
    logic [PINS-1:0]         cfg_a [NPORT];
    logic [PINS-1:0]         drv_a [NPORT];
    logic [PINS-1:0]         lvl_a [NPORT];
    logic [NPIN-1:0]         smp;

    gpio_bank_decode #(
        .NPORT (NPORT),
        .PINS  (PINS),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_decode (
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .wr_cfg (wr_cfg),
        .wr_drv (wr_drv),
        .wr_lvl (wr_lvl),
        .wmask  (wmask),
        .wval   (wval),
        .rd_grp (rd_grp),
        .rd_port(rd_port)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_port_regs #(.PINS(PINS)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_cfg  (wr_cfg[p]),
            .wr_drv  (wr_drv[p]),
            .wr_lvl  (wr_lvl[p]),
            .wmask   (wmask),
            .wval    (wval),
            .cfg     (cfg_a[p]),
            .drv     (drv_a[p]),
            .lvl     (lvl_a[p]),
            .port_oe (pad_oe[p*PINS +: PINS]),
            .port_out(pad_out[p*PINS +: PINS])
        );
    end

    gpio_pad_sync #(
        .WIDTH (NPIN),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (smp)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t          rd_d, rd_q;
    logic [PINS-1:0] rd_byte;

    always_comb begin
        rd_byte = '0;
        case (rd_grp)
            GRP_CFG: rd_byte = cfg_a[rd_port];
            GRP_DRV: rd_byte = drv_a[rd_port];
            GRP_LVL: rd_byte = lvl_a[rd_port];
            GRP_SMP: rd_byte = smp[rd_port*PINS +: PINS];
            default: rd_byte = '0;
        endcase
        rd_d.rdata = DATA_W'(rd_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NPORT  = DEF_PORTS,
    parameter int PINS   = DEF_PINS,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_we,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NPORT*PINS-1:0] pad_out,
    input logic [NPORT*PINS-1:0] pad_oe
);

    localparam int PSEL_W    = $clog2(NPORT);
    localparam int GRP_LSB   = WORD_LSB + PSEL_W;
    localparam int ALIAS_BIT = GRP_LSB + GRP_W;

    logic [GRP_W-1:0] grp;
    logic             unused_bits;

    assign grp         = bus_addr[GRP_LSB +: GRP_W];
    assign unused_bits = ^{bus_addr[GRP_LSB-1:0], bus_wdata[DATA_W-1:2*PINS],
                           bus_wdata[PINS-1:0], bus_rdata[PINS-1:0]};

    // R1: outputs are clear in the first cycle after reset release
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

    // R5: a pad never carries a high level while not driving
    a_r5_out_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    // R4: an alias write with an empty mask leaves the pads unchanged
    a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[ALIAS_BIT] && bus_wdata[PINS +: PINS] == '0)
        |=> ($stable(pad_oe) && $stable(pad_out)));

    // R6: writes to the input-sample group leave the pads unchanged
    a_r6_smp_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && grp == GRP_SMP) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R8: writes to undefined groups leave the pads unchanged
    a_r8_undef_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && grp >= 3'd4) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R8: reads of undefined groups return zero
    a_r8_undef_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (grp >= 3'd4) |=> (bus_rdata == '0));

    // R7: upper read data bits stay zero
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PINS] == '0);

endmodule

bind gpio_bank_regs gpio_bank_checker #(
    .NPORT (NPORT),
    .PINS  (PINS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/gpio_bank_regs_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    always #4 clk = ~clk;

    gpio_bank_regs dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t   sb_q[$];
    logic       rd_issue;
    int         n_chk = 0;
    int         n_err = 0;
    logic [7:0] m_cfg [4];
    logic [7:0] m_drv [4];
    logic [7:0] m_lvl [4];
    logic [31:0] m_pad;
    bit         done = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Expected-state model built from the requirements
    function automatic void mdl_reset();
        for (int p = 0; p < 4; p++) begin
            m_cfg[p] = '0; m_drv[p] = '0; m_lvl[p] = '0;
        end
    endfunction

    function automatic void mdl_wr(input logic [7:0] a, input logic [31:0] d);
        logic [7:0] sel;
        int p;
        p   = int'(a[3:2]);
        sel = a[7] ? d[15:8] : 8'hFF;
        case (a[6:4])
            3'd0: m_cfg[p] = (m_cfg[p] & ~sel) | (d[7:0] & sel);
            3'd1: m_drv[p] = (m_drv[p] & ~sel) | (d[7:0] & sel);
            3'd2: m_lvl[p] = (m_lvl[p] & ~sel) | (d[7:0] & sel);
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] mdl_rd(input logic [7:0] a);
        int p;
        p = int'(a[3:2]);
        case (a[6:4])
            3'd0: return {24'h0, m_cfg[p]};
            3'd1: return {24'h0, m_drv[p]};
            3'd2: return {24'h0, m_lvl[p]};
            3'd3: return {24'h0, m_pad[p*8 +: 8]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        mdl_wr(a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.exp = e; it.tag = tag;
        bus_addr = a; bus_we = 1'b0; rd_issue = 1'b1;
        sb_q.push_back(it);
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        rd_exp(a, mdl_rd(a), tag);
    endtask

    task automatic chk_pads(input string tag);
        logic [31:0] e_oe, e_out;
        for (int p = 0; p < 4; p++) begin
            e_oe[p*8 +: 8]  = m_cfg[p] & m_drv[p];
            e_out[p*8 +: 8] = m_cfg[p] & m_drv[p] & m_lvl[p];
        end
        chk(pad_oe == e_oe, {tag, " pad_oe"}, pad_oe, e_oe);
        chk(pad_out == e_out, {tag, " pad_out"}, pad_out, e_out);
    endtask

    // Scoreboard monitor: compares read data one cycle after each read
    initial begin
        forever begin
            bit iss;
            @(posedge clk);
            iss = rd_issue;
            @(negedge clk);
            if (iss) begin
                sb_item_t it;
                it = sb_q.pop_front();
                chk(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        pad_in = '0; rd_issue = 1'b0; m_pad = '0;
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on pads and all control registers
        chk_pads("R1");
        for (int g = 0; g < 3; g++)
            for (int p = 0; p < 4; p++)
                rd(8'((g << 4) | (p << 2)), "R1 reset read");

        // R3: plain writes with junk in the upper data bytes
        wr(8'h00, 32'h1234_00FF);
        wr(8'h10, 32'hABCD_000F);
        wr(8'h20, 32'h5A5A_00A5);
        chk_pads("R5 port0");
        rd(8'h00, "R3 cfg0");
        rd(8'h10, "R3 drv0");
        rd(8'h20, "R3 lvl0");

        // R4: masked alias writes
        wr(8'hA0, 32'h0000_F00F);
        rd(8'h20, "R4 clear upper pins");
        wr(8'hA0, 32'h0000_0CFF);
        rd(8'h20, "R4 set pins 3:2");
        wr(8'hA0, 32'hFFFF_00FF);
        rd(8'h20, "R4 empty mask");
        chk_pads("R4");

        // R2/R5: port 2 through aliases, pad mapping
        wr(8'h88, 32'h0000_FFFF);
        wr(8'h98, 32'h0000_3CFF);
        wr(8'h28, 32'h0000_0099);
        chk_pads("R2 port2");
        rd(8'h88, "R7 alias read cfg2");
        rd(8'h98, "R7 alias read drv2");
        rd(8'h29, "R2 low addr bits ignored");

        // R5: drive-enable without configuration does not drive
        wr(8'h14, 32'h0000_00FF);
        wr(8'h24, 32'h0000_00FF);
        chk_pads("R5 cfg gating");
        wr(8'h84, 32'h0000_0808);
        chk_pads("R5 single pin");

        // R6: synchronizer latency, old/old/new
        pad_in = 32'hDEAD_BEEF;
        rd_exp(8'h30, 32'h0, "R6 same cycle");
        rd_exp(8'h30, 32'h0, "R6 one cycle");
        rd_exp(8'h30, 32'hEF, "R6 two cycles");
        m_pad = 32'hDEAD_BEEF;
        rd(8'h34, "R6 port1");
        rd(8'h38, "R6 port2");
        rd(8'h3C, "R6 port3");
        rd(8'hB4, "R7 alias of sample");
        wr(8'h30, 32'h0000_FFFF);
        wr(8'hB0, 32'h0000_FF00);
        rd(8'h30, "R6 write ignored");
        chk_pads("R6");

        // R8: undefined groups
        wr(8'h40, 32'h0000_FFFF);
        wr(8'hC4, 32'h0000_FFFF);
        wr(8'h70, 32'h0000_FFFF);
        chk_pads("R8 writes ignored");
        rd(8'h40, "R8 read zero");
        rd(8'h5C, "R8 read zero");
        rd(8'hF0, "R8 read zero");
        rd(8'h00, "R8 state kept");

        // R7: read right after write
        wr(8'h2C, 32'h0000_0077);
        rd(8'h2C, "R7 read after write");
        wr(8'h8C, 32'h0000_FFFF);
        wr(8'h9C, 32'h0000_FFFF);
        chk_pads("R7 port3");

        // R1: reset asserted mid-run
        rst_n = 1'b0;
        mdl_reset();
        @(negedge clk);
        chk_pads("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h2C, "R1 cleared lvl3");
        rd(8'h8C, "R1 cleared cfg3");

        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule